// File: doc/BRIEF.md
# Page Replacement Policy Engine

This block keeps track of which virtual pages currently sit in a small set of physical page frames and decides what happens on every page reference. A reference arrives as a single-cycle valid pulse carrying a page number. One cycle later the block answers whether the page was already resident (a hit) or had to be brought in (a fault). On a hit it names the frame holding the page. On a fault it names the frame that receives the page and, when every frame was already occupied, it flags the eviction and names the page that was pushed out.

Two eviction policies share the same datapath. In first-in-first-out mode the page that was loaded earliest is replaced, and hits leave the order untouched. In least-recently-used mode every hit refreshes the page, so the page that has gone longest without a reference is replaced. The policy is sampled while reset is held and stays fixed until the next reset. Saturating hit and fault counters run alongside. The result is a checkable model for comparing replacement behaviour on reference strings, including the case where FIFO faults more often with more frames.

Top module: `page_replace_engine`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, every frame is empty, `hits_o` and `faults_o` are 0 and `rsp_valid_o` is 0.
- R2: A reference presented with `ref_valid_i` high yields `rsp_valid_o` high exactly one cycle later; a cycle with `ref_valid_i` low yields `rsp_valid_o` low one cycle later.
- R3: A fault while some frame is empty loads the page into the lowest-numbered empty frame (frames fill in the order 0, 1, 2, ...), reports that frame on `rsp_frame_o` with `rsp_hit_o` = 0 and `rsp_evict_o` = 0.
- R4: A reference to a resident page reports `rsp_hit_o` = 1, the frame that holds it on `rsp_frame_o`, `rsp_evict_o` = 0, and loads nothing.
- R5: With `policy_i` = 0 (FIFO) captured at reset, a fault with all frames full evicts the page loaded earliest; hits do not change the eviction order.
- R6: With `policy_i` = 1 (LRU) captured at reset, a fault with all frames full evicts the page whose latest reference is oldest; every hit makes its page the most recent.
- R7: On an eviction `rsp_evict_o` = 1, `rsp_victim_o` gives the evicted page and `rsp_frame_o` gives the frame it vacated, which now holds the new page.
- R8: `hits_o` increments by one per hit and `faults_o` by one per fault, each holding at its all-ones value instead of wrapping.
- R9: With 3 frames, the string 4,7,6,1,7,6,1,2,7,2 gives 6 faults and 4 hits under both policies; under FIFO the string 1,2,3,4,1,2,5,1,2,3,4,5 gives 9 faults with 3 frames and 10 faults with 4 frames.
- R10: Changes of `policy_i` while `rst_n` is high have no effect on eviction choices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; policy is sampled while low |
| policy_i | input | 1 | 0 = FIFO, 1 = LRU; captured during reset only |
| ref_valid_i | input | 1 | A page reference is presented this cycle |
| ref_page_i | input | PAGE_W | Referenced page number |
| rsp_valid_o | output | 1 | Response to the reference of the previous cycle |
| rsp_hit_o | output | 1 | 1 = page was resident, 0 = fault |
| rsp_frame_o | output | FW | Frame hit or frame loaded |
| rsp_evict_o | output | 1 | A resident page was evicted by this fault |
| rsp_victim_o | output | PAGE_W | Evicted page (0 when no eviction) |
| hits_o | output | CNT_W | Saturating hit count |
| faults_o | output | CNT_W | Saturating fault count |

## Verification
The hardest situation to reach is a full frame set whose FIFO and LRU orders disagree, because only then does the policy choice change the victim; the stimulus fills the frames, hits the oldest page and then faults, so a wrong order shows as a wrong victim page. A second instance with one more frame is driven with the same stream so the 12-reference string exposes the FIFO anomaly directly in the fault counts. Toggling the policy input in mid-stream on that same disagreement pattern shows that only the reset-time value matters, and long runs of misses and repeated hits drive both counters into saturation.

// File: rtl/pre_pkg.sv
package pre_pkg;
    typedef enum logic {
        POL_FIFO = 1'b0,
        POL_LRU  = 1'b1
    } policy_e;
endpackage

// File: rtl/pre_lookup.sv
// Parallel tag compare over all frames; reports the matching frame.
module pre_lookup #(
    parameter int N      = 4,
    parameter int PAGE_W = 8,
    parameter int FW     = 2
) (
    input  logic [N-1:0][PAGE_W-1:0] page_i,
    input  logic [N-1:0]             valid_i,
    input  logic [PAGE_W-1:0]        key_i,
    output logic                     hit_o,
    output logic [FW-1:0]            idx_o,
    output logic [N-1:0]             match_o
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match_o[g] = valid_i[g] && (page_i[g] == key_i);
    end

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (match_o[i]) idx_o = FW'(i);
        end
    end

    assign hit_o = |match_o;
endmodule

// File: rtl/pre_rank.sv
// Age rank per frame: 0 = newest/most recent, N-1 = next victim once full.
module pre_rank #(
    parameter int N  = 4,
    parameter int RW = 2,
    parameter int FW = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 touch_i,
    input  logic [FW-1:0]        idx_i,
    input  logic [RW-1:0]        lim_i,
    input  logic [N-1:0]         valid_i,
    output logic [N-1:0][RW-1:0] rank_o,
    output logic [FW-1:0]        oldest_o
);
    typedef struct packed {
        logic [N-1:0][RW-1:0] rank;
    } rank_state_t;

    rank_state_t st_d, st_q;
    logic [N-1:0] oldest_vec;

    always_comb begin
        st_d = st_q;
        if (touch_i) begin
            for (int i = 0; i < N; i++) begin
                if (FW'(i) == idx_i) begin
                    st_d.rank[i] = '0;
                end else if (valid_i[i] && (st_q.rank[i] < lim_i)) begin
                    st_d.rank[i] = st_q.rank[i] + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        oldest_o = '0;
        for (int i = 0; i < N; i++) begin
            oldest_vec[i] = (st_q.rank[i] == RW'(N - 1));
            if (oldest_vec[i]) oldest_o = FW'(i);
        end
    end

    assign rank_o = st_q.rank;

    // With every frame occupied exactly one frame must be the eviction candidate.
    assert_single_victim_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (&valid_i) |-> $onehot(oldest_vec));
    // R6: a touched frame becomes the most recent one.
    assert_touch_newest_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (touch_i && valid_i[0] && idx_i == '0) |=> (rank_o[0] == '0));
endmodule

// File: rtl/page_replace_engine.sv
module page_replace_engine
    import pre_pkg::*;
#(
    parameter int N      = 4,
    parameter int PAGE_W = 8,
    parameter int CNT_W  = 16,
    localparam int FW    = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              policy_i,
    input  logic              ref_valid_i,
    input  logic [PAGE_W-1:0] ref_page_i,
    output logic              rsp_valid_o,
    output logic              rsp_hit_o,
    output logic [FW-1:0]     rsp_frame_o,
    output logic              rsp_evict_o,
    output logic [PAGE_W-1:0] rsp_victim_o,
    output logic [CNT_W-1:0]  hits_o,
    output logic [CNT_W-1:0]  faults_o
);
    localparam int RW = FW;
    localparam int OW = $clog2(N + 1);
    localparam logic [CNT_W-1:0] CMAX = '1;

    typedef struct packed {
        policy_e                  pol;
        logic [N-1:0][PAGE_W-1:0] pages;
        logic [N-1:0]             valid;
        logic [OW-1:0]            occ;
        logic [CNT_W-1:0]         hits;
        logic [CNT_W-1:0]         faults;
        logic                     rsp_valid;
        logic                     rsp_hit;
        logic [FW-1:0]            rsp_frame;
        logic                     rsp_evict;
        logic [PAGE_W-1:0]        rsp_victim;
    } eng_state_t;

    eng_state_t st_d, st_q;

    logic                 hit_w;
    logic [FW-1:0]        hit_idx_w;
    logic [N-1:0]         match_w;
    logic [N-1:0][RW-1:0] rank_w;
    logic [FW-1:0]        oldest_w;
    logic                 full_w;
    logic [FW-1:0]        fill_idx_w;
    logic                 touch_d;
    logic [FW-1:0]        touch_idx_d;
    logic [RW-1:0]        touch_lim_d;

    pre_lookup #(.N(N), .PAGE_W(PAGE_W), .FW(FW)) u_lookup (
        .page_i  (st_q.pages),
        .valid_i (st_q.valid),
        .key_i   (ref_page_i),
        .hit_o   (hit_w),
        .idx_o   (hit_idx_w),
        .match_o (match_w)
    );

    pre_rank #(.N(N), .RW(RW), .FW(FW)) u_rank (
        .clk      (clk),
        .rst_n    (rst_n),
        .touch_i  (touch_d),
        .idx_i    (touch_idx_d),
        .lim_i    (touch_lim_d),
        .valid_i  (st_q.valid),
        .rank_o   (rank_w),
        .oldest_o (oldest_w)
    );

    assign full_w     = (st_q.occ == OW'(N));
    assign fill_idx_w = full_w ? oldest_w : FW'(st_q.occ);

    always_comb begin
        st_d            = st_q;
        st_d.rsp_valid  = 1'b0;
        st_d.rsp_hit    = 1'b0;
        st_d.rsp_frame  = '0;
        st_d.rsp_evict  = 1'b0;
        st_d.rsp_victim = '0;
        touch_d         = 1'b0;
        touch_idx_d     = '0;
        touch_lim_d     = '0;

        if (ref_valid_i) begin
            st_d.rsp_valid = 1'b1;
            if (hit_w) begin
                st_d.rsp_hit   = 1'b1;
                st_d.rsp_frame = hit_idx_w;
                st_d.hits      = (st_q.hits == CMAX) ? st_q.hits : st_q.hits + 1'b1;
                touch_d        = (st_q.pol == POL_LRU);
                touch_idx_d    = hit_idx_w;
                for (int i = 0; i < N; i++) begin
                    if (FW'(i) == hit_idx_w) touch_lim_d = rank_w[i];
                end
            end else begin
                st_d.rsp_frame = fill_idx_w;
                st_d.rsp_evict = full_w;
                st_d.faults    = (st_q.faults == CMAX) ? st_q.faults : st_q.faults + 1'b1;
                for (int i = 0; i < N; i++) begin
                    if (FW'(i) == fill_idx_w) begin
                        if (full_w) st_d.rsp_victim = st_q.pages[i];
                        st_d.pages[i] = ref_page_i;
                        st_d.valid[i] = 1'b1;
                    end
                end
                if (!full_w) st_d.occ = st_q.occ + 1'b1;
                touch_d     = 1'b1;
                touch_idx_d = fill_idx_w;
                touch_lim_d = full_w ? RW'(N - 1) : RW'(st_q.occ);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.pol <= policy_e'(policy_i);
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid_o  = st_q.rsp_valid;
    assign rsp_hit_o    = st_q.rsp_hit;
    assign rsp_frame_o  = st_q.rsp_frame;
    assign rsp_evict_o  = st_q.rsp_evict;
    assign rsp_victim_o = st_q.rsp_victim;
    assign hits_o       = st_q.hits;
    assign faults_o     = st_q.faults;

    // A page may be resident in at most one frame.
    assert_single_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_w));
    assert_resp_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ref_valid_i |=> rsp_valid_o);
    assert_resp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_valid_i |=> !rsp_valid_o);
    assert_free_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_valid_i && !hit_w && !full_w) |=>
            (!rsp_evict_o && !rsp_hit_o && rsp_frame_o == FW'($past(st_q.occ))));
    assert_evict_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_valid_i && !hit_w && full_w) |=> rsp_evict_o);
    assert_fault_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (faults_o == CMAX) |=> (faults_o == CMAX));
    assert_hit_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_valid_i && hit_w && hits_o != CMAX) |=> (hits_o == $past(hits_o) + 1'b1));
    assert_policy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(st_q.pol));
endmodule

// File: tb/page_replace_engine_bench.sv
module page_replace_engine_bench;
    localparam int PW = 4;
    localparam int CW = 4;
    localparam int CSAT = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic policy = 1'b0;
    logic ref_valid = 1'b0;
    logic [PW-1:0] ref_page = '0;

    logic rv [2];
    logic rh [2];
    logic [1:0] rf [2];
    logic re [2];
    logic [PW-1:0] rvic [2];
    logic [CW-1:0] hc [2];
    logic [CW-1:0] fc [2];

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;
    int pol_model = 0;

    int ord [2][8];
    int osz [2];
    int frm [2][16];
    int nfr [2];
    int e_hits [2];
    int e_faults [2];

    always #2.5 clk = ~clk;

    page_replace_engine #(.N(3), .PAGE_W(PW), .CNT_W(CW)) u_page_replace_engine (
        .clk(clk), .rst_n(rst_n), .policy_i(policy),
        .ref_valid_i(ref_valid), .ref_page_i(ref_page),
        .rsp_valid_o(rv[0]), .rsp_hit_o(rh[0]), .rsp_frame_o(rf[0]),
        .rsp_evict_o(re[0]), .rsp_victim_o(rvic[0]),
        .hits_o(hc[0]), .faults_o(fc[0])
    );

    page_replace_engine #(.N(4), .PAGE_W(PW), .CNT_W(CW)) u_page_replace_engine_f4 (
        .clk(clk), .rst_n(rst_n), .policy_i(policy),
        .ref_valid_i(ref_valid), .ref_page_i(ref_page),
        .rsp_valid_o(rv[1]), .rsp_hit_o(rh[1]), .rsp_frame_o(rf[1]),
        .rsp_evict_o(re[1]), .rsp_victim_o(rvic[1]),
        .hits_o(hc[1]), .faults_o(fc[1])
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int k = 0; k < 2; k++) begin
            osz[k] = 0;
            e_hits[k] = 0;
            e_faults[k] = 0;
            for (int p = 0; p < 16; p++) frm[k][p] = -1;
        end
    endtask

    // R1: reset clears everything and captures the policy.
    task automatic do_reset(input int pol);
        @(negedge clk);
        rst_n = 1'b0;
        ref_valid = 1'b0;
        policy = pol[0];
        pol_model = pol;
        model_clear();
        repeat (2) @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            chk(rv[k] == 1'b0, "R1", "rsp_valid in reset", int'(rv[k]), 0);
            chk(hc[k] == 0 && fc[k] == 0, "R1", "counters in reset",
                int'(hc[k]) + int'(fc[k]), 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 2; k++)
            chk(rv[k] == 1'b0, "R1", "rsp_valid after reset", int'(rv[k]), 0);
    endtask

    // Present one reference at a negedge; compare the response one cycle later.
    task automatic step(input int pg);
        bit x_hit [2];
        int x_frame [2];
        bit x_ev [2];
        int x_vic [2];
        ref_valid = 1'b1;
        ref_page = pg[PW-1:0];
        for (int k = 0; k < 2; k++) begin
            x_ev[k] = 1'b0;
            x_vic[k] = 0;
            if (frm[k][pg] >= 0) begin
                x_hit[k] = 1'b1;
                x_frame[k] = frm[k][pg];
                if (e_hits[k] < CSAT) e_hits[k]++;
                if (pol_model == 1) begin
                    int pos = 0;
                    for (int i = 0; i < osz[k]; i++) if (ord[k][i] == pg) pos = i;
                    for (int i = pos; i > 0; i--) ord[k][i] = ord[k][i-1];
                    ord[k][0] = pg;
                end
            end else begin
                x_hit[k] = 1'b0;
                if (e_faults[k] < CSAT) e_faults[k]++;
                if (osz[k] < nfr[k]) begin
                    x_frame[k] = osz[k];
                    osz[k]++;
                end else begin
                    x_ev[k] = 1'b1;
                    x_vic[k] = ord[k][nfr[k]-1];
                    x_frame[k] = frm[k][x_vic[k]];
                    frm[k][x_vic[k]] = -1;
                end
                for (int i = osz[k] - 1; i > 0; i--) ord[k][i] = ord[k][i-1];
                ord[k][0] = pg;
                frm[k][pg] = x_frame[k];
            end
        end
        @(negedge clk);
        ref_valid = 1'b0;
        for (int k = 0; k < 2; k++) begin
            string tag;
            int act;
            int exp;
            if (x_hit[k]) tag = "R4";
            else if (!x_ev[k]) tag = "R3";
            else tag = (pol_model == 1) ? "R6,R7" : "R5,R7";
            act = {int'(rv[k]), int'(rh[k]), int'(rf[k]), int'(re[k]), int'(rvic[k])};
            exp = {1'b1, x_hit[k], x_frame[k][1:0], x_ev[k], x_vic[k][PW-1:0]};
            act = (int'(rv[k]) << 12) | (int'(rh[k]) << 11) | (int'(rf[k]) << 8)
                | (int'(re[k]) << 7) | int'(rvic[k]);
            exp = (1 << 12) | (int'(x_hit[k]) << 11) | (x_frame[k] << 8)
                | (int'(x_ev[k]) << 7) | x_vic[k];
            chk(act == exp, tag, $sformatf("inst%0d page %0d {v,hit,frame,ev,victim}", k, pg),
                act, exp);
            chk(int'(hc[k]) == e_hits[k], "R8", $sformatf("inst%0d hits", k),
                int'(hc[k]), e_hits[k]);
            chk(int'(fc[k]) == e_faults[k], "R8", $sformatf("inst%0d faults", k),
                int'(fc[k]), e_faults[k]);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            ref_valid = 1'b0;
            @(negedge clk);
            for (int k = 0; k < 2; k++)
                chk(rv[k] == 1'b0, "R2", "rsp_valid on idle cycle", int'(rv[k]), 0);
        end
    endtask

    int str_a [10] = '{4, 7, 6, 1, 7, 6, 1, 2, 7, 2};
    int str_b [12] = '{1, 2, 3, 4, 1, 2, 5, 1, 2, 3, 4, 5};

    initial begin
        nfr[0] = 3;
        nfr[1] = 4;
        model_clear();

        // FIFO on the ten-reference string.
        do_reset(0);
        foreach (str_a[i]) step(str_a[i]);
        chk(fc[0] == 6, "R9", "FIFO 3 frames faults string A", int'(fc[0]), 6);
        chk(hc[0] == 4, "R9", "FIFO 3 frames hits string A", int'(hc[0]), 4);
        idle(2);

        // LRU on the same string.
        do_reset(1);
        foreach (str_a[i]) step(str_a[i]);
        chk(fc[0] == 6, "R9", "LRU 3 frames faults string A", int'(fc[0]), 6);
        chk(hc[0] == 4, "R9", "LRU 3 frames hits string A", int'(hc[0]), 4);

        // FIFO anomaly string on 3 and 4 frames.
        do_reset(0);
        foreach (str_b[i]) step(str_b[i]);
        chk(fc[0] == 9, "R9", "FIFO 3 frames faults string B", int'(fc[0]), 9);
        chk(fc[1] == 10, "R9", "FIFO 4 frames faults string B", int'(fc[1]), 10);

        // LRU on the anomaly string, checked step by step against the model.
        do_reset(1);
        foreach (str_b[i]) step(str_b[i]);

        // Disagreement pattern: the oldest page is hit then a fault follows.
        do_reset(0);
        step(1); step(2); step(3); step(1); step(4);
        chk(re[0] && rvic[0] == 1, "R5", "FIFO victim after hit on oldest", int'(rvic[0]), 1);
        do_reset(1);
        step(1); step(2); step(3); step(1); step(4);
        chk(re[0] && rvic[0] == 2, "R6", "LRU victim after hit on oldest", int'(rvic[0]), 2);

        // Policy pin changed after reset must not matter.
        do_reset(0);
        step(1); step(2); step(3);
        policy = 1'b1;
        step(1); step(4);
        chk(rvic[0] == 1, "R10", "victim ignores late policy change", int'(rvic[0]), 1);
        step(1);
        chk(rh[0] == 1'b0, "R10", "page 1 gone under reset-time FIFO", int'(rh[0]), 0);
        policy = 1'b0;

        // Pseudo-random stream under both policies.
        for (int p = 0; p < 2; p++) begin
            int lf = 8'h5a;
            do_reset(p);
            for (int i = 0; i < 60; i++) begin
                lf = ((lf << 1) | (((lf >> 7) ^ (lf >> 5) ^ (lf >> 4) ^ (lf >> 3)) & 1)) & 8'hff;
                step(lf % 7);
                if (i % 9 == 0) idle(1);
            end
        end

        // Counter saturation: long run of misses, then long run of hits.
        do_reset(0);
        for (int i = 0; i < 20; i++) step(i % 6);
        chk(fc[0] == CSAT, "R8", "fault counter saturated", int'(fc[0]), CSAT);
        for (int i = 0; i < 20; i++) step(5);
        chk(hc[0] == CSAT, "R8", "hit counter saturated", int'(hc[0]), CSAT);
        idle(1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule